// File: doc/BRIEF.md
# BCD calendar clock with alarm

This block keeps the time of day and the calendar date as six packed-BCD bytes: seconds, minutes, hours, day of month, month and a two-digit year. A one-hertz enable pulse moves the time forward by one second. Each field that wraps passes a carry to the next field up, within that same update. The day of month wraps at the length of the current month, and February is one day longer when the year count is a multiple of four. The year runs from 00 to 99, so one century is covered.

Software reaches every register through a simple byte bus. Reads are combinational. Writes take effect at the clock edge. A control byte opens or closes the path for writes. It also holds a test bit that makes the clock advance on every cycle, and a hold bit that stops it. A second set of six BCD bytes holds an alarm time, and an alarm control byte enables each of the six fields and the alarm as a whole. When an advance produces a time that agrees with the alarm in every enabled field, a one-cycle pulse appears on the alarm output.

Top module: `bcd_cal_clock`

## Requirements
- R1: After a synchronous reset the time reads 00:00:00 on day 01, month 01, year 00. The control byte, the alarm control byte and all alarm fields read 00, and alarm_irq is low.
- R2: The register map decodes as follows.
  - Address 0 is the control byte: bit 0 is write enable, bit 1 is fast count, bit 2 is hold.
  - Addresses 1 to 6 are the seconds, minutes, hours, day, month and year, in BCD.
  - Address 7 is the alarm control byte: bits 0 to 5 enable the fields from seconds up to year, and bit 6 is the global enable.
  - Addresses 8 to 13 are the alarm fields, in the same order as addresses 1 to 6.
  - Reads are combinational. Every other address reads 00.
- R3: A write to addresses 1 to 13 takes effect only while control bit 0 is set. The control byte can always be written, and reads are never gated.
- R4: Seconds and minutes count 00 to 59 and hours count 00 to 23, in BCD. Each field that wraps increments the next field up on the same advance.
- R5: The day of month wraps to 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months except 02. Month 12 wraps to 01 and carries into the year, and year 99 wraps to 00.
- R6: February has 29 days when the year value is a multiple of 4, and 28 days otherwise.
- R7: An advance happens on any cycle where tick_1hz is high, and on every cycle while control bit 1 is set. No advance happens while control bit 2 is set.
- R8: A time-field write in the same cycle as an advance stores the written value, and that advance is dropped for all fields.
- R9: When an advance produces a time that equals the alarm fields in every enabled field, and the global enable is set, alarm_irq is high for the one cycle in which the new time first reads back. Fields whose enable is clear are ignored. With no field enabled, every advance raises the pulse.
- R10: While the global alarm enable is clear, alarm_irq stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse per second that advances the time |
| bus_wr | input | 1 | Write strobe for the byte bus |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| alarm_irq | output | 1 | One-cycle alarm pulse |

## Verification
The bound checker verifies on every cycle the following properties:
- the hold bit freezes the time;
- a blocked write leaves the time unchanged;
- seconds at 59 return to 00 on an advance;
- an alarm pulse only follows a real advance with the global enable set.

Some behaviour is only visible through the bench's scenarios, which compare every cycle against a behavioural calendar model:
- month lengths and leap Februaries;
- the full wrap from year 99;
- the masking of alarm fields;
- a write colliding with a tick;
- the exact count of alarm pulses over a window.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 4;
    localparam int NFIELD  = 6;

    localparam logic [BYTE_W-1:0] SEC_TOP  = 8'd59;
    localparam logic [BYTE_W-1:0] MIN_TOP  = 8'd59;
    localparam logic [BYTE_W-1:0] HOUR_TOP = 8'd23;
    localparam logic [BYTE_W-1:0] MON_TOP  = 8'd12;
    localparam logic [BYTE_W-1:0] YEAR_TOP = 8'd99;

    localparam logic [ADDR_W-1:0] ADR_CTRL = 4'd0;
    localparam logic [ADDR_W-1:0] ADR_TIME = 4'd1;
    localparam logic [ADDR_W-1:0] ADR_ACTL = 4'd7;
    localparam logic [ADDR_W-1:0] ADR_ALM  = 4'd8;

    typedef enum logic [2:0] {
        FLD_SEC  = 3'd0,
        FLD_MIN  = 3'd1,
        FLD_HOUR = 3'd2,
        FLD_DAY  = 3'd3,
        FLD_MON  = 3'd4,
        FLD_YEAR = 3'd5
    } fld_e;

    typedef logic [NFIELD-1:0][BYTE_W-1:0] cal_t;

    typedef struct packed {
        logic hold;
        logic fast;
        logic wen;
    } ctrl_t;

    typedef struct packed {
        logic              glob;
        logic [NFIELD-1:0] fen;
    } actl_t;

    localparam cal_t CAL_RESET = 48'h00_01_01_00_00_00;

    function automatic logic [BYTE_W-1:0] bcd_to_bin(input logic [BYTE_W-1:0] b);
        return 8'(b[7:4]) * 8'd10 + 8'(b[3:0]);
    endfunction

    function automatic logic [BYTE_W-1:0] bin_to_bcd(input logic [BYTE_W-1:0] v);
        logic [BYTE_W-1:0] tens;
        logic [BYTE_W-1:0] ones;
        tens = v / 8'd10;
        ones = v % 8'd10;
        return {tens[3:0], ones[3:0]};
    endfunction

    // true when the field sits at (or beyond) its top value
    function automatic logic at_top(input logic [BYTE_W-1:0] cur, input logic [BYTE_W-1:0] top);
        return bcd_to_bin(cur) >= top;
    endfunction

    // next value of one field when it receives a carry
    function automatic logic [BYTE_W-1:0] bcd_next(input logic [BYTE_W-1:0] cur,
                                                   input logic [BYTE_W-1:0] low,
                                                   input logic [BYTE_W-1:0] top);
        if (at_top(cur, top))
            return bin_to_bcd(low);
        return bin_to_bcd(bcd_to_bin(cur) + 8'd1);
    endfunction

    function automatic logic [BYTE_W-1:0] month_len(input logic [BYTE_W-1:0] mon_bcd,
                                                    input logic [BYTE_W-1:0] yr_bcd);
        logic [BYTE_W-1:0] m;
        logic [BYTE_W-1:0] y;
        m = bcd_to_bin(mon_bcd);
        y = bcd_to_bin(yr_bcd);
        case (m)
            8'd2:                    return (y[1:0] == 2'b00) ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11: return 8'd30;
            default:                 return 8'd31;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] field_low(input fld_e f);
        return (f == FLD_DAY || f == FLD_MON) ? 8'd1 : 8'd0;
    endfunction

endpackage

// File: rtl/bcd_time_chain.sv
module bcd_time_chain
    import bcd_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic [NFIELD-1:0] wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output cal_t              now_q,
    output cal_t              next_o
);

    cal_t              top_c;
    logic [NFIELD-1:0] carry;

    always_comb begin
        top_c[FLD_SEC]  = SEC_TOP;
        top_c[FLD_MIN]  = MIN_TOP;
        top_c[FLD_HOUR] = HOUR_TOP;
        top_c[FLD_DAY]  = month_len(now_q[FLD_MON], now_q[FLD_YEAR]);
        top_c[FLD_MON]  = MON_TOP;
        top_c[FLD_YEAR] = YEAR_TOP;
    end

    assign carry[0] = 1'b1;

    for (genvar i = 0; i < NFIELD; i++) begin : g_field
        assign next_o[i] = carry[i]
                         ? bcd_next(now_q[i], field_low(fld_e'(i)), top_c[i])
                         : now_q[i];
        if (i < NFIELD - 1) begin : g_carry
            assign carry[i+1] = carry[i] & at_top(now_q[i], top_c[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            now_q <= CAL_RESET;
        end else if (|wr_sel) begin
            for (int i = 0; i < NFIELD; i++) begin
                if (wr_sel[i])
                    now_q[i] <= wr_data;
            end
        end else if (adv) begin
            now_q <= next_o;
        end
    end

endmodule

// File: rtl/bcd_alarm_match.sv
module bcd_alarm_match
    import bcd_cal_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  fire,
    input  cal_t  cand,
    input  cal_t  target,
    input  actl_t ctl,
    output logic  irq_q
);

    logic [NFIELD-1:0] agree;

    for (genvar i = 0; i < NFIELD; i++) begin : g_cmp
        assign agree[i] = (cand[i] == target[i]) | ~ctl.fen[i];
    end

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else
            irq_q <= fire & ctl.glob & (&agree);
    end

endmodule

// File: rtl/bcd_cal_clock.sv
module bcd_cal_clock
    import bcd_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1hz,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              alarm_irq
);

    ctrl_t             ctrl_q;
    actl_t             actl_q;
    cal_t              alm_q;
    cal_t              now_q;
    cal_t              next_c;
    logic [NFIELD-1:0] time_sel;
    logic [NFIELD-1:0] alm_sel;
    logic              adv;
    logic              any_time_wr;
    logic              adv_eff;

    for (genvar i = 0; i < NFIELD; i++) begin : g_dec
        assign time_sel[i] = bus_wr & ctrl_q.wen & (bus_addr == ADR_TIME + 4'(i));
        assign alm_sel[i]  = bus_wr & ctrl_q.wen & (bus_addr == ADR_ALM + 4'(i));
    end

    assign adv         = ~ctrl_q.hold & (tick_1hz | ctrl_q.fast);
    assign any_time_wr = |time_sel;
    assign adv_eff     = adv & ~any_time_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            actl_q <= '0;
            alm_q  <= '0;
        end else begin
            if (bus_wr && bus_addr == ADR_CTRL)
                ctrl_q <= ctrl_t'(bus_wdata[2:0]);
            if (bus_wr && ctrl_q.wen && bus_addr == ADR_ACTL)
                actl_q <= actl_t'(bus_wdata[NFIELD:0]);
            for (int i = 0; i < NFIELD; i++) begin
                if (alm_sel[i])
                    alm_q[i] <= bus_wdata;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADR_CTRL)
            bus_rdata = BYTE_W'(ctrl_q);
        else if (bus_addr == ADR_ACTL)
            bus_rdata = BYTE_W'(actl_q);
        for (int i = 0; i < NFIELD; i++) begin
            if (bus_addr == ADR_TIME + 4'(i))
                bus_rdata = now_q[i];
            if (bus_addr == ADR_ALM + 4'(i))
                bus_rdata = alm_q[i];
        end
    end

    bcd_time_chain u_chain (
        .clk     (clk),
        .rst     (rst),
        .adv     (adv),
        .wr_sel  (time_sel),
        .wr_data (bus_wdata),
        .now_q   (now_q),
        .next_o  (next_c)
    );

    bcd_alarm_match u_alarm (
        .clk    (clk),
        .rst    (rst),
        .fire   (adv_eff),
        .cand   (next_c),
        .target (alm_q),
        .ctl    (actl_q),
        .irq_q  (alarm_irq)
    );

endmodule

// File: rtl/bcd_cal_clock_chk.sv
module bcd_cal_clock_chk
    import bcd_cal_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              adv_eff,
    input logic              any_time_wr,
    input logic              hold,
    input logic              wen,
    input logic              glob,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input cal_t              now_time,
    input logic              alarm_irq
);

    assert_hold_freeze_R7: assert property (@(posedge clk) disable iff (rst)
        (hold && !any_time_wr) |=> $stable(now_time));

    assert_blocked_write_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !wen && bus_addr >= ADR_TIME && bus_addr < ADR_ACTL && !adv_eff)
            |=> $stable(now_time));

    assert_sec_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (adv_eff && now_time[0] == 8'h59) |=> (now_time[0] == 8'h00));

    assert_irq_after_advance_R9: assert property (@(posedge clk) disable iff (rst)
        alarm_irq |-> $past(adv_eff));

    assert_irq_needs_global_R10: assert property (@(posedge clk) disable iff (rst)
        alarm_irq |-> $past(glob));

endmodule

bind bcd_cal_clock bcd_cal_clock_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .adv_eff     (adv_eff),
    .any_time_wr (any_time_wr),
    .hold        (ctrl_q.hold),
    .wen         (ctrl_q.wen),
    .glob        (actl_q.glob),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .now_time    (now_q),
    .alarm_irq   (alarm_irq)
);

// File: tb/bcd_cal_clock_test.sv
`timescale 1ns/100ps
module bcd_cal_clock_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_addr = 4'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       alarm_irq;

    always #2.5 clk = ~clk;

    bcd_cal_clock uut (
        .clk       (clk),
        .rst       (rst),
        .tick_1hz  (tick),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .alarm_irq (alarm_irq)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;
    int irq_seen = 0;

    // behavioural reference state: time held as plain binary integers
    int m_t[6] = '{0, 0, 0, 1, 1, 0};
    int m_alm[6] = '{0, 0, 0, 0, 0, 0};
    int m_actl = 0;
    int m_ctrl = 0;
    bit m_irq = 0;

    function automatic int to_bcd(int v);
        return (v / 10) * 16 + (v % 10);
    endfunction

    function automatic int from_bcd(int b);
        return (b / 16) * 10 + (b % 16);
    endfunction

    function automatic int mdays(int mo, int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic int model_rd(int a);
        if (a == 0) return m_ctrl;
        if (a >= 1 && a <= 6) return to_bcd(m_t[a-1]);
        if (a == 7) return m_actl;
        if (a >= 8 && a <= 13) return m_alm[a-8];
        return 0;
    endfunction

    task automatic model_edge();
        bit adv;
        bit tw;
        bit en;
        bit hit;
        int nt[6];
        int dm;
        int a;
        a = int'(bus_addr);
        en = (m_ctrl & 1) != 0;
        adv = ((m_ctrl & 4) == 0) && (tick || ((m_ctrl & 2) != 0));
        tw = bus_wr && en && a >= 1 && a <= 6;
        nt = m_t;
        if (adv && !tw) begin
            dm = mdays(m_t[4], m_t[5]);
            nt[0]++;
            if (nt[0] > 59) begin
                nt[0] = 0; nt[1]++;
                if (nt[1] > 59) begin
                    nt[1] = 0; nt[2]++;
                    if (nt[2] > 23) begin
                        nt[2] = 0; nt[3]++;
                        if (nt[3] > dm) begin
                            nt[3] = 1; nt[4]++;
                            if (nt[4] > 12) begin
                                nt[4] = 1; nt[5]++;
                                if (nt[5] > 99) nt[5] = 0;
                            end
                        end
                    end
                end
            end
        end
        hit = adv && !tw && ((m_actl & 64) != 0);
        for (int i = 0; i < 6; i++)
            if (((m_actl >> i) & 1) != 0 && to_bcd(nt[i]) != m_alm[i]) hit = 0;
        m_irq = hit;
        if (tw) nt[a-1] = from_bcd(int'(bus_wdata));
        m_t = nt;
        if (bus_wr) begin
            if (a == 0) m_ctrl = int'(bus_wdata) & 7;
            else if (en && a == 7) m_actl = int'(bus_wdata) & 127;
            else if (en && a >= 8 && a <= 13) m_alm[a-8] = int'(bus_wdata);
        end
    endtask

    task automatic chk(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic cyc(string tag);
        model_edge();
        @(posedge clk);
        #1;
        chk(tag, "alarm_irq", int'(alarm_irq), int'(m_irq));
        chk(tag, "rdata", int'(bus_rdata), model_rd(int'(bus_addr)));
        if (alarm_irq) irq_seen++;
    endtask

    task automatic wr(int a, int d, string tag);
        bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = 8'(d); tick = 1'b0;
        cyc(tag);
        bus_wr = 1'b0;
    endtask

    task automatic rd(int a, string tag);
        bus_addr = 4'(a);
        cyc(tag);
    endtask

    task automatic tk(string tag);
        tick = 1'b1;
        cyc(tag);
        tick = 1'b0;
    endtask

    task automatic set_time(int s, int mi, int h, int d, int mo, int y, string tag);
        wr(1, to_bcd(s), tag);
        wr(2, to_bcd(mi), tag);
        wr(3, to_bcd(h), tag);
        wr(4, to_bcd(d), tag);
        wr(5, to_bcd(mo), tag);
        wr(6, to_bcd(y), tag);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        int saved;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;

        // R1: reset contents
        for (int a = 0; a < 16; a++) rd(a, "R1");
        rd(4, "R1"); chk("R1", "day", int'(bus_rdata), 8'h01);

        // R3: writes blocked while the write enable is clear
        wr(1, 8'h30, "R3");
        wr(8, 8'h12, "R3");
        rd(1, "R3"); chk("R3", "sec", int'(bus_rdata), 8'h00);
        rd(8, "R3"); chk("R3", "alm sec", int'(bus_rdata), 8'h00);

        // R2: control write, map decoding
        wr(0, 8'hF9, "R2");
        rd(0, "R2"); chk("R2", "ctrl", int'(bus_rdata), 8'h01);
        rd(15, "R2"); chk("R2", "unmapped", int'(bus_rdata), 8'h00);

        // R5: complete wrap from the last second of year 99
        set_time(58, 59, 23, 31, 12, 99, "R2");
        tk("R5"); tk("R5");
        for (int a = 1; a <= 6; a++) rd(a, "R5");
        rd(6, "R5"); chk("R5", "year", int'(bus_rdata), 8'h00);
        rd(5, "R5"); chk("R5", "month", int'(bus_rdata), 8'h01);
        set_time(59, 59, 23, 30, 4, 10, "R5");
        tk("R5");
        rd(4, "R5"); chk("R5", "day after apr30", int'(bus_rdata), 8'h01);
        rd(5, "R5"); chk("R5", "month after apr30", int'(bus_rdata), 8'h05);

        // R6: leap and common Februaries
        set_time(59, 59, 23, 28, 2, 24, "R6");
        tk("R6");
        rd(4, "R6"); chk("R6", "leap feb29", int'(bus_rdata), 8'h29);
        tk("R6");
        set_time(59, 59, 23, 29, 2, 24, "R6");
        tk("R6");
        rd(4, "R6"); chk("R6", "day after feb29", int'(bus_rdata), 8'h01);
        rd(5, "R6"); chk("R6", "month after feb29", int'(bus_rdata), 8'h03);
        set_time(59, 59, 23, 28, 2, 23, "R6");
        tk("R6");
        rd(4, "R6"); chk("R6", "common feb28", int'(bus_rdata), 8'h01);

        // R4: BCD digit carry and minute/hour cascade
        set_time(59, 59, 9, 10, 6, 10, "R4");
        tk("R4");
        rd(3, "R4"); chk("R4", "hour", int'(bus_rdata), 8'h10);
        rd(2, "R4"); chk("R4", "min", int'(bus_rdata), 8'h00);
        bus_addr = 4'd1;
        repeat (75) tk("R4");
        rd(2, "R4"); chk("R4", "min after 75s", int'(bus_rdata), 8'h01);
        rd(1, "R4"); chk("R4", "sec after 75s", int'(bus_rdata), 8'h15);

        // R9: alarm on seconds only
        set_time(0, 0, 0, 1, 1, 0, "R9");
        wr(8, 8'h05, "R9");
        wr(7, 8'h41, "R9");
        irq_seen = 0;
        bus_addr = 4'd1;
        repeat (10) tk("R9");
        chk("R9", "sec-only pulses", irq_seen, 1);
        wr(9, 8'h07, "R9");
        wr(7, 8'h43, "R9");
        irq_seen = 0;
        repeat (60) tk("R9");
        chk("R9", "masked mismatch pulses", irq_seen, 0);
        wr(7, 8'h40, "R9");
        irq_seen = 0;
        repeat (5) tk("R9");
        chk("R9", "no-field pulses", irq_seen, 5);

        // R10: global enable clear
        wr(7, 8'h01, "R10");
        irq_seen = 0;
        repeat (70) tk("R10");
        chk("R10", "pulses", irq_seen, 0);

        // R7: fast count and hold
        wr(0, 8'h03, "R7");
        bus_addr = 4'd1;
        repeat (130) cyc("R7");
        wr(0, 8'h05, "R7");
        rd(1, "R7");
        saved = int'(bus_rdata);
        repeat (10) tk("R7");
        rd(1, "R7"); chk("R7", "held sec", int'(bus_rdata), saved);
        wr(0, 8'h01, "R7");

        // R8: write and tick in the same cycle
        set_time(10, 20, 5, 3, 3, 30, "R8");
        tick = 1'b1; bus_wr = 1'b1; bus_addr = 4'd1; bus_wdata = 8'h40;
        cyc("R8");
        tick = 1'b0; bus_wr = 1'b0;
        rd(1, "R8"); chk("R8", "sec", int'(bus_rdata), 8'h40);
        rd(2, "R8"); chk("R8", "min", int'(bus_rdata), 8'h20);

        // mixed traffic against the model
        for (int n = 0; n < 4000; n++) begin
            int r;
            int f;
            int lim[6];
            lim = '{60, 60, 24, 28, 12, 100};
            r = int'($urandom % 16);
            tick = (($urandom % 3) == 0);
            if (r == 0) begin
                int opts[5];
                opts = '{1, 1, 3, 5, 0};
                bus_wr = 1'b1; bus_addr = 4'd0; bus_wdata = 8'(opts[$urandom % 5]);
            end else if (r <= 3) begin
                f = int'($urandom % 6);
                bus_wr = 1'b1; bus_addr = 4'(f + 1);
                bus_wdata = 8'(to_bcd(int'($urandom % lim[f]) + ((f == 3 || f == 4) ? 1 : 0)));
            end else if (r == 4) begin
                bus_wr = 1'b1; bus_addr = 4'd7; bus_wdata = 8'($urandom % 128);
            end else if (r == 5) begin
                bus_wr = 1'b1; bus_addr = 4'(8 + $urandom % 2);
                bus_wdata = 8'(to_bcd(int'($urandom % 60)));
            end else begin
                bus_addr = 4'($urandom % 16);
            end
            cyc("R4");
            bus_wr = 1'b0; tick = 1'b0;
        end
        wr(0, 8'h01, "R4");

        finished = 1;
        summary();
        $finish;
    end

endmodule